// File: doc/BRIEF.md
# Matrix Keyboard Scan Encoder

The block walks an 8x8 key matrix one position at a time. A 6-bit scan counter selects one drive row, shown as a one-hot output, and one sense column. The counter steps on each falling edge of a bus timing strobe. When the selected position reads closed for a full press-debounce window, the scan stops and the position number is latched as the key code. An active-low data-available flag then goes low for the host.

The host reads the code by asserting both chip selects across a rising strobe edge. This clears data-available. If the key is still held at a later rising edge, an active-low repeat flag goes low so the host can auto-repeat. Opening the key starts a release-debounce window. When that window expires, repeat returns high, and the scan resumes once the code has also been read. Keys are reported in scan order, not in the order they were pressed.

Debounce lengths are counted in strobe periods. Any bounce restarts the window that is running. All logic is synchronous to `clk`. The strobe is sampled and its edges are detected in the clock domain.

Top module: `kbd_scan_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge: `da_n` and `rpt_n` go to 1, the scan counter goes to 0 (`drive_row` = 8'h01), `key_code` goes to 0 and the debounce machine goes idle.
- R2: The key code is the scan count at detection. Its upper 3 bits select the driven row (bit n of `drive_row` high) and its lower 3 bits select the sensed column (`sense_col` bit, high = closed). `key_code` stays stable while `da_n` is low.
- R3: After a closure is first seen at a falling strobe edge, it must still read closed at the next PRESS_TICKS falling edges. At the last of these, `da_n` goes low and the counter stays frozen.
- R4: `da_n` returns high at a rising strobe edge when `sel_hi`=1 and `sel_lo_n`=0. A read while `da_n` is already high changes no output.
- R5: After the read, if the key is still held (not in release debounce) at a rising strobe edge, `rpt_n` goes low.
- R6: After the held key opens, `rpt_n` goes high only at the falling edge where the key has read open for RELEASE_TICKS+1 consecutive falling edges (the first sees the opening).
- R7: A key that reads open during the press window abandons the detection without raising `da_n`. A key that reads closed during the release window restarts that window.
- R8: While scanning with the current position open, each falling strobe edge advances the counter by one, wrapping from 63 to 0. Exactly one `drive_row` bit is high at all times.
- R9: After a report, the scan moves to the next position only on a falling edge once both the read and the release debounce are complete. Keys held together are reported in counter order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe | input | 1 | Bus timing strobe; falls advance the scan, rises perform reads |
| sel_hi | input | 1 | Active-high chip select |
| sel_lo_n | input | 1 | Active-low chip select |
| drive_row | output | 8 | One-hot row drive for the current scan position |
| sense_col | input | 8 | Column sense lines, 1 = key closed on the driven row |
| key_code | output | 6 | Latched position of the reported key |
| da_n | output | 1 | Data available, active low |
| rpt_n | output | 1 | Auto-repeat indication, active low |

## Verification
The bench holds two keys down at once and checks that the lower scan position is reported first. A design that reported press order, or that resumed scanning before the read, would give the higher code first. It releases a key and counts the exact falling edge at which repeat clears. An off-by-one release counter moves that edge, and clearing repeat on the opening itself gives up the release debounce. It also bounces a key inside the press window, which catches a design that keeps a partial count. Finally it runs the counter through its wrap and issues a read with data-available already high, which must leave every output unchanged.

// File: rtl/kbd_scan_pkg.sv
// Shared types for the keyboard scan encoder.
package kbd_scan_pkg;
    // Debounce / handshake phases of the encoder.
    typedef enum logic [2:0] {
        ST_SCAN     = 3'd0,
        ST_PRESS_DB = 3'd1,
        ST_HELD     = 3'd2,
        ST_REL_DB   = 3'd3,
        ST_WAIT_RD  = 3'd4
    } kbd_state_e;
endpackage

// File: rtl/kbd_strobe_edge.sv
// Samples the timing strobe and produces one-clock pulses for its rising
// and falling edges. Assumes the strobe is already synchronous to clk.
module kbd_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise,
    output logic fall
);
    logic strobe_q;

    // Hold the strobe from the previous clock for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign rise = strobe & ~strobe_q;
    assign fall = ~strobe & strobe_q;
endmodule

// File: rtl/kbd_scan_counter.sv
// Scan position counter with one-hot row drive and column sense select.
// Assumes the sense lines are valid while the current row is driven.
module kbd_scan_counter #(
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           advance,
    input  logic [(1<<COL_BITS)-1:0]       sense_col,
    output logic [(1<<ROW_BITS)-1:0]       drive_row,
    output logic [ROW_BITS+COL_BITS-1:0]   count,
    output logic                           hit
);
    localparam int CODE_W = ROW_BITS + COL_BITS;
    localparam int ROWS   = 1 << ROW_BITS;

    // Step the scan position; natural binary wrap covers the whole matrix.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (advance) count <= count + CODE_W'(1);
    end

    // Decode the upper bits into one driven row line each.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign drive_row[r] = (count[CODE_W-1:COL_BITS] == ROW_BITS'(r));
    end

    assign hit = sense_col[count[COL_BITS-1:0]];
endmodule

// File: rtl/kbd_debounce_fsm.sv
// Press/release debounce and host handshake. Produces the scan advance,
// the code latch pulse and the active-low data-available and repeat flags.
// Assumes rise and fall never pulse in the same clock.
module kbd_debounce_fsm
    import kbd_scan_pkg::*;
#(
    parameter int PRESS_TICKS   = 4,
    parameter int RELEASE_TICKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    input  logic read_sel,
    input  logic hit,
    output logic advance,
    output logic latch,
    output logic da_n,
    output logic rpt_n
);
    localparam int MAX_T = (PRESS_TICKS > RELEASE_TICKS) ? PRESS_TICKS : RELEASE_TICKS;
    localparam int DB_W  = $clog2(MAX_T + 1);
    localparam logic [DB_W-1:0] P_LAST = DB_W'(PRESS_TICKS - 1);
    localparam logic [DB_W-1:0] R_LAST = DB_W'(RELEASE_TICKS - 1);

    kbd_state_e      st;
    logic [DB_W-1:0] db_cnt;

    assign latch   = fall && (st == ST_PRESS_DB) && hit && (db_cnt == P_LAST);
    assign advance = fall && (((st == ST_SCAN) && !hit) || ((st == ST_WAIT_RD) && da_n));

    // Sequence debounce windows and the host flags on strobe edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_SCAN;
            db_cnt <= '0;
            da_n   <= 1'b1;
            rpt_n  <= 1'b1;
        end else begin
            if (rise) begin
                if (read_sel && !da_n)
                    da_n <= 1'b1;
                else if (da_n && (st == ST_HELD) && rpt_n)
                    rpt_n <= 1'b0;
            end
            if (fall) begin
                case (st)
                    ST_SCAN: begin
                        if (hit) begin
                            st     <= ST_PRESS_DB;
                            db_cnt <= '0;
                        end
                    end
                    ST_PRESS_DB: begin
                        if (!hit) begin
                            st <= ST_SCAN;
                        end else if (db_cnt == P_LAST) begin
                            st   <= ST_HELD;
                            da_n <= 1'b0;
                        end else begin
                            db_cnt <= db_cnt + DB_W'(1);
                        end
                    end
                    ST_HELD: begin
                        if (!hit) begin
                            st     <= ST_REL_DB;
                            db_cnt <= '0;
                        end
                    end
                    ST_REL_DB: begin
                        if (hit) begin
                            st <= ST_HELD;
                        end else if (db_cnt == R_LAST) begin
                            st    <= ST_WAIT_RD;
                            rpt_n <= 1'b1;
                        end else begin
                            db_cnt <= db_cnt + DB_W'(1);
                        end
                    end
                    ST_WAIT_RD: begin
                        if (da_n) st <= ST_SCAN;
                    end
                    default: st <= ST_SCAN;
                endcase
            end
        end
    end
endmodule

// File: rtl/kbd_scan_encoder.sv
// Keyboard matrix scan encoder top. Ties the strobe edge detector, the
// scan counter and the debounce/handshake machine together and holds
// the reported key code. Assumes a synchronous strobe and key matrix.
module kbd_scan_encoder #(
    parameter int ROW_BITS      = 3,
    parameter int COL_BITS      = 3,
    parameter int PRESS_TICKS   = 4,
    parameter int RELEASE_TICKS = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                strobe,
    input  logic                                sel_hi,
    input  logic                                sel_lo_n,
    output logic [(1<<ROW_BITS)-1:0]            drive_row,
    input  logic [(1<<COL_BITS)-1:0]            sense_col,
    output logic [ROW_BITS+COL_BITS-1:0]        key_code,
    output logic                                da_n,
    output logic                                rpt_n
);
    localparam int CODE_W = ROW_BITS + COL_BITS;

    logic              rise, fall, hit, advance, latch;
    logic [CODE_W-1:0] count;

    kbd_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .rise   (rise),
        .fall   (fall)
    );

    kbd_scan_counter #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .sense_col (sense_col),
        .drive_row (drive_row),
        .count     (count),
        .hit       (hit)
    );

    kbd_debounce_fsm #(.PRESS_TICKS(PRESS_TICKS), .RELEASE_TICKS(RELEASE_TICKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fall     (fall),
        .read_sel (sel_hi & ~sel_lo_n),
        .hit      (hit),
        .advance  (advance),
        .latch    (latch),
        .da_n     (da_n),
        .rpt_n    (rpt_n)
    );

    // Capture the scan position when a closure is confirmed.
    always_ff @(posedge clk) begin
        if (!rst_n)     key_code <= '0;
        else if (latch) key_code <= count;
    end
endmodule

// File: rtl/kbd_scan_encoder_chk.sv
// Port-level protocol checker for the scan encoder, bound to every instance.
module kbd_scan_encoder_chk #(
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          strobe,
    input logic                          sel_hi,
    input logic                          sel_lo_n,
    input logic [(1<<ROW_BITS)-1:0]      drive_row,
    input logic [ROW_BITS+COL_BITS-1:0]  key_code,
    input logic                          da_n,
    input logic                          rpt_n
);
    logic strobe_d;

    // Previous strobe sample, kept independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_d <= 1'b0;
        else        strobe_d <= strobe;
    end

    AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!da_n && $past(!da_n)) |-> $stable(key_code)); // R2
    AST_DA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(da_n) |-> $past(!strobe && strobe_d)); // R3
    AST_SCAN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!da_n && $past(!da_n)) |-> $stable(drive_row)); // R3
    AST_DA_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(da_n) |-> $past(strobe && !strobe_d && sel_hi && !sel_lo_n)); // R4
    AST_RPT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rpt_n) |-> $past(strobe && !strobe_d && da_n)); // R5
    AST_RPT_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rpt_n) |-> $past(!strobe && strobe_d)); // R6
    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drive_row) == 1); // R8
    AST_ROW_STEP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drive_row) |-> $past(!strobe && strobe_d)); // R8
endmodule

bind kbd_scan_encoder kbd_scan_encoder_chk #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .sel_hi    (sel_hi),
    .sel_lo_n  (sel_lo_n),
    .drive_row (drive_row),
    .key_code  (key_code),
    .da_n      (da_n),
    .rpt_n     (rpt_n)
);

// File: tb/kbd_scan_encoder_bench.sv
module kbd_scan_encoder_bench;
    localparam int P = 3;
    localparam int R = 4;
    localparam int S_SCAN = 0, S_PDB = 1, S_HELD = 2, S_RDB = 3, S_WAIT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic       sel_hi = 1'b0;
    logic       sel_lo_n = 1'b1;
    logic [7:0] drive_row;
    logic [7:0] sense_col;
    logic [5:0] key_code;
    logic       da_n, rpt_n;
    logic [63:0] keys = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    int m_cnt, m_st, m_db, m_code;
    bit m_da_n, m_rpt_n;

    always #10 clk = ~clk;

    kbd_scan_encoder #(.PRESS_TICKS(P), .RELEASE_TICKS(R)) u_kbd_scan_encoder (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .drive_row(drive_row), .sense_col(sense_col), .key_code(key_code),
        .da_n(da_n), .rpt_n(rpt_n));

    // Key matrix: a closed key connects its driven row to its column.
    always_comb begin
        sense_col = '0;
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 8; r++)
                if (drive_row[r] && keys[r*8+c]) sense_col[c] = 1'b1;
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int row_of(int code);
        return 1 << (code / 8);
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_st = S_SCAN; m_db = 0; m_code = 0; m_da_n = 1; m_rpt_n = 1;
    endtask

    task automatic model_rise(bit rd);
        if (rd && !m_da_n) m_da_n = 1;
        else if (m_da_n && m_st == S_HELD && m_rpt_n) m_rpt_n = 0;
    endtask

    task automatic model_fall();
        bit h = keys[m_cnt];
        case (m_st)
            S_SCAN: if (h) begin m_st = S_PDB; m_db = 0; end else m_cnt = (m_cnt + 1) % 64;
            S_PDB:  if (!h) m_st = S_SCAN;
                    else if (m_db == P-1) begin m_st = S_HELD; m_da_n = 0; m_code = m_cnt; end
                    else m_db++;
            S_HELD: if (!h) begin m_st = S_RDB; m_db = 0; end
            S_RDB:  if (h) m_st = S_HELD;
                    else if (m_db == R-1) begin m_st = S_WAIT; m_rpt_n = 1; end
                    else m_db++;
            default: if (m_da_n) begin m_st = S_SCAN; m_cnt = (m_cnt + 1) % 64; end
        endcase
    endtask

    // One strobe period: rise (read when rd), then fall, then compare.
    task automatic tpb_cycle(bit rd);
        @(negedge clk);
        sel_hi = rd; sel_lo_n = !rd; strobe = 1'b1;
        model_rise(rd);
        repeat (2) @(negedge clk);
        strobe = 1'b0; sel_hi = 1'b0; sel_lo_n = 1'b1;
        model_fall();
        repeat (2) @(negedge clk);
        check("R3 da_n", da_n, m_da_n);
        check("R5 rpt_n", rpt_n, m_rpt_n);
        check("R2 key_code", key_code, m_code);
        check("R8 drive_row", drive_row, row_of(m_cnt));
    endtask

    task automatic run_until_da(int limit);
        for (int i = 0; i < limit && da_n; i++) tpb_cycle(0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 da_n", da_n, 1);
        check("R1 rpt_n", rpt_n, 1);
        check("R1 drive_row", drive_row, 8'h01);
        check("R1 key_code", key_code, 0);

        // Read with nothing pending: no output may change (R4).
        tpb_cycle(1);
        check("R4 idle read da_n", da_n, 1);
        check("R4 idle read rpt_n", rpt_n, 1);

        // Two keys held together: lower scan position first (R9).
        keys[10] = 1'b1; keys[40] = 1'b1;
        run_until_da(100);
        check("R9 first code", key_code, 10);
        tpb_cycle(0);
        check("R3 frozen row", drive_row, 8'h02);
        tpb_cycle(1);
        check("R4 read clears", da_n, 1);
        tpb_cycle(0);
        check("R5 repeat low", rpt_n, 0);
        keys[10] = 1'b0;
        for (int i = 0; i < R; i++) tpb_cycle(0);
        check("R6 repeat held in window", rpt_n, 0);
        tpb_cycle(0);
        check("R6 repeat released", rpt_n, 1);
        run_until_da(100);
        check("R9 second code", key_code, 40);
        keys[40] = 1'b0;
        tpb_cycle(1);
        for (int i = 0; i < R + 3; i++) tpb_cycle(0);

        // Bounce inside the press window (R7).
        keys[m_cnt] = 1'b1;
        begin
            int k;
            k = m_cnt;
            tpb_cycle(0); tpb_cycle(0);
            keys[k] = 1'b0;
            tpb_cycle(0);
            check("R7 bounce no report", da_n, 1);
            keys[k] = 1'b1;
            for (int i = 0; i < P; i++) tpb_cycle(0);
            check("R7 restart not yet", da_n, 1);
            tpb_cycle(0);
            check("R7 restart reports", da_n, 0);
            check("R2 code after restart", key_code, k);
            keys[k] = 1'b0;
        end
        tpb_cycle(1);
        for (int i = 0; i < R + 3; i++) tpb_cycle(0);

        // Counter wrap 63 -> 0 (R8).
        for (int i = 0; i < 80 && m_cnt != 63; i++) tpb_cycle(0);
        tpb_cycle(0);
        check("R8 wrap", drive_row, 8'h01);

        // Constrained random traffic with bounces and sporadic reads.
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom % 16;
            if (r < 2) keys[$urandom % 64] ^= 1'b1;
            else if (r == 2 && $countones(keys) > 3) keys = '0;
            tpb_cycle(($urandom % 4) == 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule